// File: doc/BRIEF.md
# Indexed Mixer Control Register File

This block holds the 8-bit control registers of an audio mixer behind an indirect host port. The host first writes an index byte, which selects either the plain register space or the extended register space and a register number within it. It then writes a data byte to the selected register, or reads the selected register back on a combinational read bus. The stored values are decoded into named control outputs. These outputs drive the sample-rate selection, the wavetable mute, the digital routing features and the AUX1 and DAC2 volume paths of the surrounding mixer.

Three behaviours make the block more than a plain register array. The two wavetable mute bits take their reset value from a hardware configuration input. The 3D-enable bit has a single storage location that appears in two registers. A remap bit in the feature register makes DAC2 volume writes update the AUX1 volume as well. Reserved bits and fully reserved registers keep whatever the host writes and return it on read, with no side effect.

Top module: `mixer_ctl_regfile`

## Requirements
- R1: During a cycle with `rst_n` low, every register loads zero, except bit 7 of extended registers 0x16 and 0x17, which loads the inverse of `wt_en_cfg`. Outputs and readback show these values once reset is released.
- R2: Extended register 0x12 drives `adc_rate` and extended register 0x13 drives `dac_rate`. Both read back as written.
- R3: Bit 7 of extended 0x16 drives `wt_mute_l` and bit 7 of extended 0x17 drives `wt_mute_r`. Bits 6..0 of both registers are stored and read back unchanged.
- R4: In extended register 0x18, bit 0 drives `loopback_en`, bit 1 `vport_en`, bit 2 `sample_hold`, bit 3 `dsp_dac1`, bit 4 `en_3d`, bit 5 `aux1_remap` and bit 7 `port_en`. Bit 6 is stored and read back only.
- R5: Bit 3 of plain register 0x0C and bit 4 of extended 0x18 are one storage bit that drives `en_3d`. A write to either register sets it, and both registers read it back. The other bits of plain 0x0C are stored and read back only.
- R6: While `aux1_remap` is 1, a write to plain register 18 sets both `dac2_vol_l` and `aux1_vol_l`, and a write to plain register 19 sets both `dac2_vol_r` and `aux1_vol_r`.
- R7: While `aux1_remap` is 0, writes to plain 18 and 19 change only the DAC2 volumes. Plain registers 2 and 3 always set `aux1_vol_l` and `aux1_vol_r`.
- R8: Extended registers 0x14 and 0x15 store every bit and read it back, and a write to them changes no output.
- R9: A write to any index not named in R2 to R8 changes no output and no register, and such an index reads back 0x00.
- R10: A data write strobed at clock edge N is committed at edge N+1. Outputs and readback still show the old value between edges N and N+1 and show the new value after edge N+1.
- R11: An index write takes effect at the edge that samples it. The index byte uses bit 7 for the space (1 = extended, 0 = plain) and bits 4..0 for the register number, and bits 6..5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_en_cfg | input | 1 | Wavetable-enable bit from the hardware configuration, used for the mute reset value |
| host_idx_we | input | 1 | Index write strobe |
| host_data_we | input | 1 | Data write strobe for the selected register |
| host_wdata | input | 8 | Index or data byte from the host |
| host_rdata | output | 8 | Readback of the selected register |
| adc_rate | output | 8 | ADC sample-rate select |
| dac_rate | output | 8 | DAC sample-rate select |
| wt_mute_l | output | 1 | Left wavetable input mute |
| wt_mute_r | output | 1 | Right wavetable input mute |
| loopback_en | output | 1 | ADC-to-DAC1 digital loopback |
| vport_en | output | 1 | Video port drives DAC2 |
| sample_hold | output | 1 | Hold the last playback sample |
| dsp_dac1 | output | 1 | Serial DSP port drives DAC1 |
| en_3d | output | 1 | 3D sound enable |
| aux1_remap | output | 1 | DAC2 volume writes also set AUX1 volume |
| port_en | output | 1 | Port enable bit |
| aux1_vol_l | output | 8 | AUX1 left volume |
| aux1_vol_r | output | 8 | AUX1 right volume |
| dac2_vol_l | output | 8 | DAC2 left volume |
| dac2_vol_r | output | 8 | DAC2 right volume |

## Verification
Directed writes target each control register with distinct byte patterns, so a wrong bit position or a swapped left and right register produces a different output vector. Volume writes are made with the remap bit clear and then set, which separates the shadowing path from the plain DAC2 path. The 3D bit is written through one register and read through the other, which shows whether the two views share storage. Random sequences then mix implemented, reserved and unimplemented indices in both spaces. Each output and readback is compared with a bench model, so a write that leaks into another register is caught.

// File: rtl/mixer_ctl_pkg.sv
package mixer_ctl_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;
  localparam int N_EXT  = 7;
  localparam int CTL_W  = 2 * DATA_W + 9 + 4 * DATA_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  num_t;

  // extended space
  localparam num_t EX_BASE  = 5'h12;
  localparam num_t EX_ADC   = 5'h12;
  localparam num_t EX_DAC   = 5'h13;
  localparam num_t EX_RSV_A = 5'h14;
  localparam num_t EX_RSV_B = 5'h15;
  localparam num_t EX_WT_L  = 5'h16;
  localparam num_t EX_WT_R  = 5'h17;
  localparam num_t EX_FEAT  = 5'h18;
  localparam int   SLOT_WT_L = 4;
  localparam int   SLOT_WT_R = 5;
  localparam int   SLOT_FEAT = 6;

  // plain space
  localparam num_t PL_AUX1_L = 5'd2;
  localparam num_t PL_AUX1_R = 5'd3;
  localparam num_t PL_MODE   = 5'h0C;
  localparam num_t PL_DAC2_L = 5'd18;
  localparam num_t PL_DAC2_R = 5'd19;

  // bit positions
  localparam int MUTE_BIT   = 7;
  localparam int MODE_3D    = 3;
  localparam int FB_LOOP    = 0;
  localparam int FB_VPORT   = 1;
  localparam int FB_HOLD    = 2;
  localparam int FB_DSP     = 3;
  localparam int FB_3D      = 4;
  localparam int FB_REMAP   = 5;
  localparam int FB_PORT    = 7;

  typedef struct packed {
    logic ext;
    num_t num;
  } reg_addr_t;

  typedef struct packed {
    logic      valid;
    reg_addr_t addr;
    byte_t     data;
  } wr_cmd_t;

  function automatic reg_addr_t decode_index(input byte_t v);
    reg_addr_t a;
    a.ext = v[DATA_W-1];
    a.num = v[IDX_W-1:0];
    return a;
  endfunction

  function automatic num_t slot_num(input int i);
    return num_t'(int'(EX_BASE) + i);
  endfunction

  function automatic byte_t ext_reset_val(input int i, input logic wt_en);
    byte_t v;
    v = '0;
    if (i == SLOT_WT_L || i == SLOT_WT_R) v[MUTE_BIT] = ~wt_en;
    return v;
  endfunction

  // the 3D bit of the feature slot lives in the shared flop
  function automatic byte_t ext_store_val(input int i, input byte_t d);
    byte_t v;
    v = d;
    if (i == SLOT_FEAT) v[FB_3D] = 1'b0;
    return v;
  endfunction

  function automatic byte_t with_bit(input byte_t v, input int pos, input logic b);
    byte_t r;
    r = v;
    r[pos] = b;
    return r;
  endfunction

endpackage

// File: rtl/mixer_ctl_host_port.sv
module mixer_ctl_host_port
  import mixer_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idx_we,
  input  logic      data_we,
  input  byte_t     wdata,
  output reg_addr_t cur_addr,
  output wr_cmd_t   cmd
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cmd      <= '0;
    end else begin
      if (idx_we) cur_addr <= decode_index(wdata);
      cmd.valid <= data_we;
      if (data_we) begin
        cmd.addr <= cur_addr;
        cmd.data <= wdata;
      end
    end
  end

endmodule

// File: rtl/mixer_ctl_bank.sv
module mixer_ctl_bank
  import mixer_ctl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wt_en_cfg,
  input  wr_cmd_t                 cmd,
  output logic [N_EXT-1:0][DATA_W-1:0] ext_q,
  output byte_t                   aux1_l_q,
  output byte_t                   aux1_r_q,
  output byte_t                   dac2_l_q,
  output byte_t                   dac2_r_q,
  output byte_t                   mode_q,
  output logic                    en3d_q,
  output logic                    commit_hit
);

  logic [N_EXT-1:0] ext_hit;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    logic hit;
    assign hit = cmd.valid && cmd.addr.ext && (cmd.addr.num == slot_num(i));
    assign ext_hit[i] = hit;
    always_ff @(posedge clk) begin
      if (!rst_n)   ext_q[i] <= ext_reset_val(i, wt_en_cfg);
      else if (hit) ext_q[i] <= ext_store_val(i, cmd.data);
    end
  end

  function automatic logic plain_hit(input wr_cmd_t c, input num_t n);
    return c.valid && !c.addr.ext && (c.addr.num == n);
  endfunction

  logic hit_a1l, hit_a1r, hit_d2l, hit_d2r, hit_mode, remap;

  assign hit_a1l  = plain_hit(cmd, PL_AUX1_L);
  assign hit_a1r  = plain_hit(cmd, PL_AUX1_R);
  assign hit_d2l  = plain_hit(cmd, PL_DAC2_L);
  assign hit_d2r  = plain_hit(cmd, PL_DAC2_R);
  assign hit_mode = plain_hit(cmd, PL_MODE);
  assign remap    = ext_q[SLOT_FEAT][FB_REMAP];

  assign commit_hit = (|ext_hit) | hit_a1l | hit_a1r | hit_d2l | hit_d2r | hit_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aux1_l_q <= '0;
      aux1_r_q <= '0;
      dac2_l_q <= '0;
      dac2_r_q <= '0;
      mode_q   <= '0;
      en3d_q   <= 1'b0;
    end else begin
      if (hit_a1l || (remap && hit_d2l)) aux1_l_q <= cmd.data;
      if (hit_a1r || (remap && hit_d2r)) aux1_r_q <= cmd.data;
      if (hit_d2l) dac2_l_q <= cmd.data;
      if (hit_d2r) dac2_r_q <= cmd.data;
      if (hit_mode) begin
        mode_q <= with_bit(cmd.data, MODE_3D, 1'b0);
        en3d_q <= cmd.data[MODE_3D];
      end else if (ext_hit[SLOT_FEAT]) begin
        en3d_q <= cmd.data[FB_3D];
      end
    end
  end

endmodule

// File: rtl/mixer_ctl_view.sv
module mixer_ctl_view
  import mixer_ctl_pkg::*;
(
  input  reg_addr_t               cur_addr,
  input  logic [N_EXT-1:0][DATA_W-1:0] ext_q,
  input  byte_t                   aux1_l_q,
  input  byte_t                   aux1_r_q,
  input  byte_t                   dac2_l_q,
  input  byte_t                   dac2_r_q,
  input  byte_t                   mode_q,
  input  logic                    en3d_q,
  output byte_t                   rdata,
  output byte_t                   adc_rate,
  output byte_t                   dac_rate,
  output logic                    wt_mute_l,
  output logic                    wt_mute_r,
  output logic                    loopback_en,
  output logic                    vport_en,
  output logic                    sample_hold,
  output logic                    dsp_dac1,
  output logic                    en_3d,
  output logic                    aux1_remap,
  output logic                    port_en
);

  function automatic byte_t read_ext(input num_t n,
                                     input logic [N_EXT-1:0][DATA_W-1:0] q,
                                     input logic b3d);
    byte_t r;
    r = '0;
    for (int i = 0; i < N_EXT; i++) begin
      if (n == slot_num(i)) r = q[i];
    end
    if (n == EX_FEAT) r = with_bit(r, FB_3D, b3d);
    return r;
  endfunction

  function automatic byte_t read_plain(input num_t n, input byte_t a1l, input byte_t a1r,
                                       input byte_t d2l, input byte_t d2r,
                                       input byte_t md, input logic b3d);
    byte_t r;
    case (n)
      PL_AUX1_L: r = a1l;
      PL_AUX1_R: r = a1r;
      PL_DAC2_L: r = d2l;
      PL_DAC2_R: r = d2r;
      PL_MODE:   r = with_bit(md, MODE_3D, b3d);
      default:   r = '0;
    endcase
    return r;
  endfunction

  always_comb begin
    if (cur_addr.ext) rdata = read_ext(cur_addr.num, ext_q, en3d_q);
    else rdata = read_plain(cur_addr.num, aux1_l_q, aux1_r_q, dac2_l_q, dac2_r_q,
                            mode_q, en3d_q);
  end

  localparam int S_ADC = int'(EX_ADC - EX_BASE);
  localparam int S_DAC = int'(EX_DAC - EX_BASE);

  assign adc_rate    = ext_q[S_ADC];
  assign dac_rate    = ext_q[S_DAC];
  assign wt_mute_l   = ext_q[SLOT_WT_L][MUTE_BIT];
  assign wt_mute_r   = ext_q[SLOT_WT_R][MUTE_BIT];
  assign loopback_en = ext_q[SLOT_FEAT][FB_LOOP];
  assign vport_en    = ext_q[SLOT_FEAT][FB_VPORT];
  assign sample_hold = ext_q[SLOT_FEAT][FB_HOLD];
  assign dsp_dac1    = ext_q[SLOT_FEAT][FB_DSP];
  assign en_3d       = en3d_q;
  assign aux1_remap  = ext_q[SLOT_FEAT][FB_REMAP];
  assign port_en     = ext_q[SLOT_FEAT][FB_PORT];

endmodule

// File: rtl/mixer_ctl_regfile.sv
module mixer_ctl_regfile
  import mixer_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wt_en_cfg,
  input  logic       host_idx_we,
  input  logic       host_data_we,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] adc_rate,
  output logic [7:0] dac_rate,
  output logic       wt_mute_l,
  output logic       wt_mute_r,
  output logic       loopback_en,
  output logic       vport_en,
  output logic       sample_hold,
  output logic       dsp_dac1,
  output logic       en_3d,
  output logic       aux1_remap,
  output logic       port_en,
  output logic [7:0] aux1_vol_l,
  output logic [7:0] aux1_vol_r,
  output logic [7:0] dac2_vol_l,
  output logic [7:0] dac2_vol_r
);

  reg_addr_t cur_addr;
  wr_cmd_t   cmd;
  logic [N_EXT-1:0][DATA_W-1:0] ext_q;
  byte_t     mode_q;
  logic      en3d_q;
  logic      commit_hit;

  // named events for the checker
  logic              cmd_valid;
  logic [IDX_W:0]    cmd_addr;
  byte_t             cmd_data;
  logic [CTL_W-1:0]  ctl_bus;

  mixer_ctl_host_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_we   (host_idx_we),
    .data_we  (host_data_we),
    .wdata    (host_wdata),
    .cur_addr (cur_addr),
    .cmd      (cmd)
  );

  mixer_ctl_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wt_en_cfg  (wt_en_cfg),
    .cmd        (cmd),
    .ext_q      (ext_q),
    .aux1_l_q   (aux1_vol_l),
    .aux1_r_q   (aux1_vol_r),
    .dac2_l_q   (dac2_vol_l),
    .dac2_r_q   (dac2_vol_r),
    .mode_q     (mode_q),
    .en3d_q     (en3d_q),
    .commit_hit (commit_hit)
  );

  mixer_ctl_view u_view (
    .cur_addr    (cur_addr),
    .ext_q       (ext_q),
    .aux1_l_q    (aux1_vol_l),
    .aux1_r_q    (aux1_vol_r),
    .dac2_l_q    (dac2_vol_l),
    .dac2_r_q    (dac2_vol_r),
    .mode_q      (mode_q),
    .en3d_q      (en3d_q),
    .rdata       (host_rdata),
    .adc_rate    (adc_rate),
    .dac_rate    (dac_rate),
    .wt_mute_l   (wt_mute_l),
    .wt_mute_r   (wt_mute_r),
    .loopback_en (loopback_en),
    .vport_en    (vport_en),
    .sample_hold (sample_hold),
    .dsp_dac1    (dsp_dac1),
    .en_3d       (en_3d),
    .aux1_remap  (aux1_remap),
    .port_en     (port_en)
  );

  assign cmd_valid = cmd.valid;
  assign cmd_addr  = cmd.addr;
  assign cmd_data  = cmd.data;
  assign ctl_bus   = {adc_rate, dac_rate, wt_mute_l, wt_mute_r, loopback_en, vport_en,
                      sample_hold, dsp_dac1, en_3d, aux1_remap, port_en,
                      aux1_vol_l, aux1_vol_r, dac2_vol_l, dac2_vol_r};

endmodule

// File: rtl/mixer_ctl_regfile_chk.sv
module mixer_ctl_regfile_chk
  import mixer_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wt_en_cfg,
  input logic             host_data_we,
  input logic             cmd_valid,
  input logic [IDX_W:0]   cmd_addr,
  input logic [7:0]       cmd_data,
  input logic             commit_hit,
  input logic             aux1_remap,
  input logic [7:0]       aux1_vol_l,
  input logic [7:0]       dac2_vol_l,
  input logic             en_3d,
  input logic             wt_mute_l,
  input logic             wt_mute_r,
  input logic [CTL_W-1:0] ctl_bus
);

  localparam logic [IDX_W:0] A_DAC2_L = {1'b0, PL_DAC2_L};
  localparam logic [IDX_W:0] A_MODE   = {1'b0, PL_MODE};
  localparam logic [IDX_W:0] A_WT_L   = {1'b1, EX_WT_L};
  localparam logic [IDX_W:0] A_RSV_A  = {1'b1, EX_RSV_A};
  localparam logic [IDX_W:0] A_RSV_B  = {1'b1, EX_RSV_B};

  p_reset_mute_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wt_mute_l == !wt_en_cfg) && (wt_mute_r == !wt_en_cfg));

  p_mute_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_addr == A_WT_L |=> wt_mute_l == $past(cmd_data[MUTE_BIT]));

  p_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_addr == A_MODE |=> en_3d == $past(cmd_data[MODE_3D]));

  p_remap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_addr == A_DAC2_L && aux1_remap |=>
      (aux1_vol_l == $past(cmd_data)) && (dac2_vol_l == $past(cmd_data)));

  p_no_remap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_addr == A_DAC2_L && !aux1_remap |=> $stable(aux1_vol_l));

  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_addr == A_RSV_A || cmd_addr == A_RSV_B) |=> $stable(ctl_bus));

  p_unimpl_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !commit_hit |=> $stable(ctl_bus));

  p_commit_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_we |=> cmd_valid);

  p_stage_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(ctl_bus));

endmodule

bind mixer_ctl_regfile mixer_ctl_regfile_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wt_en_cfg    (wt_en_cfg),
  .host_data_we (host_data_we),
  .cmd_valid    (cmd_valid),
  .cmd_addr     (cmd_addr),
  .cmd_data     (cmd_data),
  .commit_hit   (commit_hit),
  .aux1_remap   (aux1_remap),
  .aux1_vol_l   (aux1_vol_l),
  .dac2_vol_l   (dac2_vol_l),
  .en_3d        (en_3d),
  .wt_mute_l    (wt_mute_l),
  .wt_mute_r    (wt_mute_r),
  .ctl_bus      (ctl_bus)
);

// File: tb/mixer_ctl_regfile_tb.sv
module mixer_ctl_regfile_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wt_en_cfg = 1'b1;
  logic       host_idx_we = 1'b0;
  logic       host_data_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, adc_rate, dac_rate, aux1_vol_l, aux1_vol_r, dac2_vol_l, dac2_vol_r;
  logic       wt_mute_l, wt_mute_r, loopback_en, vport_en, sample_hold, dsp_dac1;
  logic       en_3d, aux1_remap, port_en;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mixer_ctl_regfile dut_i (.*);

  // bench model of the register contents
  logic [7:0] mx [32];
  logic [7:0] mp [32];
  logic       m3d;

  function automatic logic is_ext_impl(input int n);
    return n >= 'h12 && n <= 'h18;
  endfunction

  function automatic logic [7:0] exp_read(input logic ext, input int n);
    logic [7:0] r;
    if (ext) begin
      r = is_ext_impl(n) ? mx[n] : 8'h00;
      if (n == 'h18) r = (r & 8'hEF) | {3'b000, m3d, 4'b0000};
    end else begin
      case (n)
        2, 3, 18, 19: r = mp[n];
        'h0C:         r = (mp[n] & 8'hF7) | {4'b0000, m3d, 3'b000};
        default:      r = 8'h00;
      endcase
    end
    return r;
  endfunction

  function automatic logic [56:0] exp_bus();
    logic [7:0] f;
    f = mx['h18];
    return {mx['h12], mx['h13], mx['h16][7], mx['h17][7], f[0], f[1], f[2], f[3], m3d,
            f[5], f[7], mp[2], mp[3], mp[18], mp[19]};
  endfunction

  function automatic logic [56:0] act_bus();
    return {adc_rate, dac_rate, wt_mute_l, wt_mute_r, loopback_en, vport_en, sample_hold,
            dsp_dac1, en_3d, aux1_remap, port_en, aux1_vol_l, aux1_vol_r, dac2_vol_l,
            dac2_vol_r};
  endfunction

  task automatic model_write(input logic ext, input int n, input logic [7:0] d);
    if (ext) begin
      if (is_ext_impl(n)) mx[n] = d;
      if (n == 'h18) m3d = d[4];
    end else begin
      case (n)
        2, 3: mp[n] = d;
        18, 19: begin
          mp[n] = d;
          if (mx['h18][5]) mp[n - 16] = d;
        end
        'h0C: begin
          mp[n] = d;
          m3d = d[3];
        end
        default: ;
      endcase
    end
  endtask

  task automatic model_clear(input logic cfg);
    for (int i = 0; i < 32; i++) begin
      mx[i] = 8'h00;
      mp[i] = 8'h00;
    end
    mx['h16] = {~cfg, 7'h00};
    mx['h17] = {~cfg, 7'h00};
    m3d = 1'b0;
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [56:0] a, e;
    a = act_bus();
    e = exp_bus();
    n_checks++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s outputs: actual %015h expected %015h", tag, a, e);
    end
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0;
    wt_en_cfg = cfg;
    host_idx_we = 1'b0;
    host_data_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear(cfg);
    @(negedge clk);
  endtask

  task automatic set_index(input logic [7:0] v);
    @(negedge clk);
    host_wdata = v;
    host_idx_we = 1'b1;
    @(negedge clk);
    host_idx_we = 1'b0;
  endtask

  // write, then wait until the commit edge has passed
  task automatic put_data(input logic ext, input int n, input logic [7:0] d);
    set_index({ext, 2'b00, 5'(n)});
    host_wdata = d;
    host_data_we = 1'b1;
    @(negedge clk);
    host_data_we = 1'b0;
    @(negedge clk);
    model_write(ext, n, d);
  endtask

  task automatic check_read(input string tag, input logic ext, input int n);
    set_index({ext, 2'b00, 5'(n)});
    check8(tag, host_rdata, exp_read(ext, n));
  endtask

  function automatic int pick_num(output logic ext);
    int k;
    k = int'($urandom % 16);
    ext = 1'b1;
    case (k)
      0: begin ext = 1'b0; return 2; end
      1: begin ext = 1'b0; return 3; end
      2: begin ext = 1'b0; return 'h0C; end
      3: begin ext = 1'b0; return 18; end
      4: begin ext = 1'b0; return 19; end
      5, 6, 7, 8, 9, 10, 11: return 'h12 + (k - 5);
      12: return 'h18;
      default: begin
        ext = 1'($urandom % 2);
        return int'($urandom % 32);
      end
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));

    // R1: reset with wavetable enabled, then disabled
    do_reset(1'b1);
    check_outputs("R1 reset cfg=1");
    check_read("R1 read 0x16", 1'b1, 'h16);
    check_read("R1 read 0x18", 1'b1, 'h18);
    do_reset(1'b0);
    check_outputs("R1 reset cfg=0");
    check_read("R1 read 0x17", 1'b1, 'h17);

    // R10: old value between the strobe edge and the commit edge
    set_index(8'h92);
    host_wdata = 8'h5A;
    host_data_we = 1'b1;
    @(negedge clk);
    host_data_we = 1'b0;
    check8("R10 before commit", adc_rate, 8'h00);
    check8("R10 readback before commit", host_rdata, 8'h00);
    @(negedge clk);
    model_write(1'b1, 'h12, 8'h5A);
    check8("R10 R2 after commit", adc_rate, 8'h5A);
    check8("R10 readback after commit", host_rdata, 8'h5A);

    // R11: bits 6..5 of the index ignored
    set_index(8'hF3);
    host_wdata = 8'h3C;
    host_data_we = 1'b1;
    @(negedge clk);
    host_data_we = 1'b0;
    @(negedge clk);
    model_write(1'b1, 'h13, 8'h3C);
    check8("R11 R2 dac_rate", dac_rate, 8'h3C);

    // R3: mute bits and stored low bits
    put_data(1'b1, 'h16, 8'h00);
    put_data(1'b1, 'h17, 8'hA5);
    check_outputs("R3 mute");
    check_read("R3 read 0x16", 1'b1, 'h16);
    check_read("R3 read 0x17", 1'b1, 'h17);

    // R4: single feature bits walked
    for (int b = 0; b < 8; b++) begin
      put_data(1'b1, 'h18, 8'(1 << b));
      check_outputs("R4 feature bit");
    end
    check_read("R4 read 0x18", 1'b1, 'h18);

    // R5: alias in both directions
    put_data(1'b0, 'h0C, 8'hFF);
    check8("R5 en_3d via plain", {7'h0, en_3d}, 8'h01);
    check_read("R5 feature view", 1'b1, 'h18);
    put_data(1'b1, 'h18, 8'h00);
    check_read("R5 plain view", 1'b0, 'h0C);
    check_outputs("R5 cleared");

    // R7 then R6
    put_data(1'b0, 2, 8'h11);
    put_data(1'b0, 3, 8'h22);
    put_data(1'b0, 18, 8'h33);
    put_data(1'b0, 19, 8'h44);
    check_outputs("R7 remap clear");
    put_data(1'b1, 'h18, 8'h20);
    put_data(1'b0, 18, 8'h55);
    put_data(1'b0, 19, 8'h66);
    check_outputs("R6 remap set");
    check8("R6 aux1_vol_l", aux1_vol_l, 8'h55);

    // R8: reserved registers
    put_data(1'b1, 'h14, 8'hC3);
    put_data(1'b1, 'h15, 8'h7E);
    check_outputs("R8 reserved quiet");
    check_read("R8 read 0x14", 1'b1, 'h14);
    check_read("R8 read 0x15", 1'b1, 'h15);

    // R9: unimplemented indices
    put_data(1'b1, 'h05, 8'hFF);
    put_data(1'b0, 'h07, 8'hFF);
    put_data(1'b1, 'h19, 8'hFF);
    check_outputs("R9 ignored");
    check_read("R9 read ext 0x05", 1'b1, 'h05);
    check_read("R9 read plain 0x07", 1'b0, 'h07);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic ext;
      int n;
      n = pick_num(ext);
      put_data(ext, n, 8'($urandom));
      check_outputs("R2 R6 R7 R9 random");
      if (it % 4 == 0) begin
        logic e2;
        int n2;
        n2 = pick_num(e2);
        check_read("R8 R9 random read", e2, n2);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule